// File: doc/BRIEF.md
# Exception Entry and Mode Controller

This block keeps the processor's current status word and moves the core between its seven operating modes when exception events arrive. It accepts six event requests: a synchronous reset request, a memory abort, a fast interrupt, a normal interrupt, an undefined-instruction trap and a software-interrupt trap. When more than one request is active in the same cycle, it picks one by a fixed ranking. Before it switches mode, it saves the old status word into the saved-status copy that belongs to the target mode. It then sets the interrupt masks and returns to the 32-bit instruction state.

Software changes the status word through a write port. Privileged code may change every field. User code may change only the condition flags. A return-from-exception strobe copies the current mode's saved status back into the live word in one cycle. A vector-select index and a one-cycle "taken" strobe tell the fetch logic which handler to start.

The status word layout is used on the write port and on every saved-status output. Bits 31..28 hold the flags N, Z, C and V. Bit 7 is I, the normal-interrupt mask. Bit 6 is F, the fast-interrupt mask. Bit 5 is T, the compressed-instruction state. Bits 4..0 hold the mode. All other bits read as zero.

Top module: `excModeCtrl`

## Requirements
- R1: After `rstN` is released, the block is in supervisor mode (10011) with I=1, F=1, T=0 and all flags 0. Every saved copy is zero, `vecIdx` is 0 and `excTaken` is 0.
- R2: When requests arrive in the same cycle, only one is taken. The ranking, highest first, is: reset, abort, fast interrupt, normal interrupt, undefined, software interrupt.
- R3: A fast interrupt is ignored while F=1, and a normal interrupt is ignored while I=1. A masked request leaves the status word and every saved copy unchanged, and lower-ranked requests are still considered.
- R4: On entry, the old status word is copied into the target mode's saved copy. The mode becomes the target. I becomes 1, T becomes 0, and the flags keep their values.
- R5: F becomes 1 on reset and on fast-interrupt entry. Every other entry leaves F as it was.
- R6: Each source enters a fixed mode and sets a fixed `vecIdx`:
  - reset: supervisor 10011, index 0
  - undefined: 11011, index 1
  - software interrupt: supervisor 10011, index 2
  - abort: 10111, index 3
  - normal interrupt: 10010, index 4
  - fast interrupt: 10001, index 5
- R7: A return strobe loads the whole status word from the current mode's saved copy, effective after one clock edge. In user (10000) or system (11111) mode the strobe is ignored.
- R8: A status write in user mode changes only the flags. Mode, I, F and T keep their values.
- R9: A status write in any other mode loads the flags, I, F and T. It also loads the mode field, but only if that field is one of the seven legal encodings; an illegal encoding leaves the mode as it was.
- R10: An exception entry takes precedence over a return strobe, and a return strobe takes precedence over a write, when they occur in the same cycle.
- R11: `excTaken` is 1 for exactly the cycle after an entry. `vecIdx` changes only on entry and otherwise holds the last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resetReq | input | 1 | Synchronous reset event request |
| abortReq | input | 1 | Memory access violation request |
| fiqReq | input | 1 | Fast interrupt request |
| irqReq | input | 1 | Normal interrupt request |
| undefReq | input | 1 | Undefined instruction request |
| swiReq | input | 1 | Software interrupt request |
| retStrobe | input | 1 | Return from exception |
| wrEn | input | 1 | Status word write enable |
| wrData | input | 32 | Status word write value |
| mode | output | 5 | Current mode |
| condFlags | output | 4 | N, Z, C, V flags (N in bit 3) |
| iMask | output | 1 | Normal-interrupt mask |
| fMask | output | 1 | Fast-interrupt mask |
| tBit | output | 1 | Compressed-instruction state |
| savedFiq | output | 32 | Saved status, fast-interrupt mode |
| savedIrq | output | 32 | Saved status, normal-interrupt mode |
| savedSvc | output | 32 | Saved status, supervisor mode |
| savedAbt | output | 32 | Saved status, abort mode |
| savedUnd | output | 32 | Saved status, undefined mode |
| vecIdx | output | 3 | Vector-select index of the last entry |
| excTaken | output | 1 | One-cycle strobe after an entry |

## Verification
The assertions assume that every request input is synchronous to `clk` and is held for a whole cycle. They also assume that the saved copies only ever receive legal status words, so a return always restores a legal mode.

The bench changes every input only on the falling edge, and it writes illegal mode encodings only through the write port. This matches the R9 rule that such writes leave the mode alone. All other events in the stimulus come from the six request lines, the return strobe and legal status writes.

// File: rtl/excPkg.sv
package excPkg;
  localparam int WORD_W    = 32;
  localparam int NUM_SAVED = 5;
  localparam int IDX_W     = $clog2(NUM_SAVED);
  localparam int VEC_W     = 3;
  localparam int MODE_W    = 5;
  localparam int FLAG_W    = 4;
  localparam int FLAG_LSB  = WORD_W - FLAG_W;
  localparam int I_POS     = 7;
  localparam int F_POS     = 6;
  localparam int T_POS     = 5;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } modeE;

  typedef enum logic [VEC_W-1:0] {
    VEC_RESET = 3'd0,
    VEC_UNDEF = 3'd1,
    VEC_SWI   = 3'd2,
    VEC_ABORT = 3'd3,
    VEC_IRQ   = 3'd4,
    VEC_FIQ   = 3'd5
  } vecE;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic              iBit;
    logic              fBit;
    logic              tBit;
    logic [MODE_W-1:0] mode;
  } statusT;

  // Strobes from control to datapath
  typedef struct packed {
    logic              doEntry;
    logic [MODE_W-1:0] entryMode;
    logic              setF;
    logic [VEC_W-1:0]  vec;
    logic              doReturn;
    logic              doWrite;
    logic              wrCtrl;
    logic [IDX_W-1:0]  savedIdx;
  } ctrlStrbT;

  function automatic logic [WORD_W-1:0] packStatus(statusT s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1:FLAG_LSB] = s.flags;
    w[I_POS] = s.iBit;
    w[F_POS] = s.fBit;
    w[T_POS] = s.tBit;
    w[MODE_W-1:0] = s.mode;
    return w;
  endfunction

  function automatic statusT unpackStatus(logic [WORD_W-1:0] w);
    statusT s;
    s.flags = w[WORD_W-1:FLAG_LSB];
    s.iBit  = w[I_POS];
    s.fBit  = w[F_POS];
    s.tBit  = w[T_POS];
    s.mode  = w[MODE_W-1:0];
    return s;
  endfunction

  function automatic logic modeLegal(logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic hasSaved(logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND: return 1'b1;
      default:                                          return 1'b0;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] savedSlot(logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return IDX_W'(0);
      MODE_IRQ: return IDX_W'(1);
      MODE_SVC: return IDX_W'(2);
      MODE_ABT: return IDX_W'(3);
      MODE_UND: return IDX_W'(4);
      default:  return IDX_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/excCtrl.sv
module excCtrl
  import excPkg::*;
(
  input  logic              resetReq,
  input  logic              abortReq,
  input  logic              fiqReq,
  input  logic              irqReq,
  input  logic              undefReq,
  input  logic              swiReq,
  input  logic              retStrobe,
  input  logic              wrEn,
  input  logic [MODE_W-1:0] curMode,
  input  logic              iMask,
  input  logic              fMask,
  output ctrlStrbT          strb
);
  logic fiqLive;
  logic irqLive;

  assign fiqLive = fiqReq && !fMask;
  assign irqLive = irqReq && !iMask;

  always_comb begin
    strb = '0;
    // fixed ranking of simultaneous events
    if (resetReq) begin
      strb.doEntry = 1'b1; strb.entryMode = MODE_SVC; strb.setF = 1'b1; strb.vec = VEC_RESET;
    end else if (abortReq) begin
      strb.doEntry = 1'b1; strb.entryMode = MODE_ABT; strb.vec = VEC_ABORT;
    end else if (fiqLive) begin
      strb.doEntry = 1'b1; strb.entryMode = MODE_FIQ; strb.setF = 1'b1; strb.vec = VEC_FIQ;
    end else if (irqLive) begin
      strb.doEntry = 1'b1; strb.entryMode = MODE_IRQ; strb.vec = VEC_IRQ;
    end else if (undefReq) begin
      strb.doEntry = 1'b1; strb.entryMode = MODE_UND; strb.vec = VEC_UNDEF;
    end else if (swiReq) begin
      strb.doEntry = 1'b1; strb.entryMode = MODE_SVC; strb.vec = VEC_SWI;
    end

    if (strb.doEntry) begin
      strb.savedIdx = savedSlot(strb.entryMode);
    end else begin
      strb.savedIdx = savedSlot(curMode);
      if (retStrobe && hasSaved(curMode)) strb.doReturn = 1'b1;
      else if (wrEn)                      strb.doWrite  = 1'b1;
    end
    strb.wrCtrl = (curMode != MODE_USR);
  end
endmodule

// File: rtl/excDatapath.sv
module excDatapath
  import excPkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  ctrlStrbT                            strb,
  input  logic [WORD_W-1:0]                   wrData,
  output statusT                              curStat,
  output logic [NUM_SAVED-1:0][WORD_W-1:0]    savedWords,
  output logic                                excTaken,
  output logic [VEC_W-1:0]                    vecIdx
);
  localparam statusT RESET_STAT = '{flags: '0, iBit: 1'b1, fBit: 1'b1, tBit: 1'b0, mode: MODE_SVC};

  statusT            curQ;
  statusT            curD;
  statusT            wrStat;
  logic [WORD_W-1:0] savedQ [NUM_SAVED];
  logic [WORD_W-1:0] retWord;

  assign wrStat = unpackStatus(wrData);

  always_comb begin
    retWord = '0;
    for (int k = 0; k < NUM_SAVED; k++) begin
      if (strb.savedIdx == IDX_W'(k)) retWord = savedQ[k];
    end
  end

  always_comb begin
    curD = curQ;
    if (strb.doEntry) begin
      curD.mode = strb.entryMode;
      curD.iBit = 1'b1;
      curD.fBit = curQ.fBit | strb.setF;
      curD.tBit = 1'b0;
    end else if (strb.doReturn) begin
      curD = unpackStatus(retWord);
    end else if (strb.doWrite) begin
      curD.flags = wrStat.flags;
      if (strb.wrCtrl) begin
        curD.iBit = wrStat.iBit;
        curD.fBit = wrStat.fBit;
        curD.tBit = wrStat.tBit;
        if (modeLegal(wrStat.mode)) curD.mode = wrStat.mode;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ     <= RESET_STAT;
      excTaken <= 1'b0;
      vecIdx   <= '0;
    end else begin
      curQ     <= curD;
      excTaken <= strb.doEntry;
      if (strb.doEntry) vecIdx <= strb.vec;
    end
  end

  for (genvar k = 0; k < NUM_SAVED; k++) begin : g_saved
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                             savedQ[k] <= '0;
      else if (strb.doEntry && strb.savedIdx == IDX_W'(k))   savedQ[k] <= packStatus(curQ);
    end
    assign savedWords[k] = savedQ[k];
  end

  assign curStat = curQ;

  // R1: the live mode is always one of the legal encodings
  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    modeLegal(curQ.mode));

  // R4: after an entry the normal mask is set and T is cleared
  a_r4_entry_masks: assert property (@(posedge clk) disable iff (!rstN)
    strb.doEntry |=> (curQ.iBit && !curQ.tBit && excTaken));

  // R5: reset and fast entries leave F set
  a_r5_f_set: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doEntry && strb.setF) |=> curQ.fBit);

  // R8: without an entry, user mode keeps its control bits
  a_r8_user_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (curQ.mode == MODE_USR && !strb.doEntry) |=>
      (curQ.mode == MODE_USR && $stable(curQ.iBit) && $stable(curQ.fBit) && $stable(curQ.tBit)));
endmodule

// File: rtl/excModeCtrl.sv
module excModeCtrl
  import excPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetReq,
  input  logic              abortReq,
  input  logic              fiqReq,
  input  logic              irqReq,
  input  logic              undefReq,
  input  logic              swiReq,
  input  logic              retStrobe,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [4:0]        mode,
  output logic [3:0]        condFlags,
  output logic              iMask,
  output logic              fMask,
  output logic              tBit,
  output logic [31:0]       savedFiq,
  output logic [31:0]       savedIrq,
  output logic [31:0]       savedSvc,
  output logic [31:0]       savedAbt,
  output logic [31:0]       savedUnd,
  output logic [2:0]        vecIdx,
  output logic              excTaken
);
  ctrlStrbT                          strb;
  statusT                            curStat;
  logic [NUM_SAVED-1:0][WORD_W-1:0]  savedWords;

  excCtrl u_ctrl (
    .resetReq (resetReq),
    .abortReq (abortReq),
    .fiqReq   (fiqReq),
    .irqReq   (irqReq),
    .undefReq (undefReq),
    .swiReq   (swiReq),
    .retStrobe(retStrobe),
    .wrEn     (wrEn),
    .curMode  (curStat.mode),
    .iMask    (curStat.iBit),
    .fMask    (curStat.fBit),
    .strb     (strb)
  );

  excDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .curStat   (curStat),
    .savedWords(savedWords),
    .excTaken  (excTaken),
    .vecIdx    (vecIdx)
  );

  assign mode      = curStat.mode;
  assign condFlags = curStat.flags;
  assign iMask     = curStat.iBit;
  assign fMask     = curStat.fBit;
  assign tBit      = curStat.tBit;
  assign savedFiq  = savedWords[0];
  assign savedIrq  = savedWords[1];
  assign savedSvc  = savedWords[2];
  assign savedAbt  = savedWords[3];
  assign savedUnd  = savedWords[4];

  // R2: a reset request always wins and lands in supervisor with F set
  a_r2_reset_wins: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> (mode == MODE_SVC && fMask && iMask && excTaken && vecIdx == VEC_RESET));

  // R3: a taken fast interrupt was not masked the cycle before
  a_r3_fiq_unmasked: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken && vecIdx == VEC_FIQ) |-> !$past(fMask));

  // R3: a taken normal interrupt was not masked the cycle before
  a_r3_irq_unmasked: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken && vecIdx == VEC_IRQ) |-> !$past(iMask));
endmodule

// File: tb/sim_excModeCtrl.sv
module sim_excModeCtrl;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] word;
    logic [31:0] sv [5];
    logic [2:0]  vec;
    logic        taken;
    string       tag;
  } expT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetReq = 0, abortReq = 0, fiqReq = 0, irqReq = 0, undefReq = 0, swiReq = 0;
  logic        retStrobe = 0, wrEn = 0;
  logic [31:0] wrData = '0;
  logic [4:0]  mode;
  logic [3:0]  condFlags;
  logic        iMask, fMask, tBit;
  logic [31:0] savedFiq, savedIrq, savedSvc, savedAbt, savedUnd;
  logic [2:0]  vecIdx;
  logic        excTaken;

  int checks = 0;
  int fails  = 0;
  expT expQ[$];

  logic [31:0] mWord;
  logic [31:0] mSaved [5];
  logic [2:0]  mVec;
  logic        mTaken;

  always #(CLK_PERIOD/2) clk = ~clk;

  excModeCtrl u0 (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .abortReq(abortReq), .fiqReq(fiqReq),
    .irqReq(irqReq), .undefReq(undefReq), .swiReq(swiReq), .retStrobe(retStrobe),
    .wrEn(wrEn), .wrData(wrData), .mode(mode), .condFlags(condFlags), .iMask(iMask),
    .fMask(fMask), .tBit(tBit), .savedFiq(savedFiq), .savedIrq(savedIrq),
    .savedSvc(savedSvc), .savedAbt(savedAbt), .savedUnd(savedUnd), .vecIdx(vecIdx),
    .excTaken(excTaken)
  );

  function automatic bit legalMode(logic [4:0] m);
    return m inside {5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
  endfunction

  function automatic int slotOf(logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [31:0] actualWord();
    return {condFlags, 20'b0, iMask, fMask, tBit, mode};
  endfunction

  task automatic compareNow(expT e);
    logic [31:0] sv [5];
    bit bad;
    sv[0] = savedFiq; sv[1] = savedIrq; sv[2] = savedSvc; sv[3] = savedAbt; sv[4] = savedUnd;
    checks++;
    bad = (actualWord() !== e.word) || (vecIdx !== e.vec) || (excTaken !== e.taken);
    for (int k = 0; k < 5; k++) if (sv[k] !== e.sv[k]) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL %s: word=%h vec=%0d taken=%0b sv=%h/%h/%h/%h/%h expected word=%h vec=%0d taken=%0b sv=%h/%h/%h/%h/%h",
        e.tag, actualWord(), vecIdx, excTaken, sv[0], sv[1], sv[2], sv[3], sv[4],
        e.word, e.vec, e.taken, e.sv[0], e.sv[1], e.sv[2], e.sv[3], e.sv[4]);
    end
  endtask

  function automatic expT snapshot(string tag);
    expT e;
    e.word = mWord; e.vec = mVec; e.taken = mTaken; e.tag = tag;
    for (int k = 0; k < 5; k++) e.sv[k] = mSaved[k];
    return e;
  endfunction

  // Driver: apply one cycle of stimulus and push the expected result
  task automatic drive(input bit rs, ab, fq, iq, ud, sw, rt, we,
                       input logic [31:0] wd, input string tag);
    logic [4:0] cm, tgt;
    bit entry, setF;
    logic [2:0] vec;
    @(negedge clk);
    resetReq = rs; abortReq = ab; fiqReq = fq; irqReq = iq; undefReq = ud; swiReq = sw;
    retStrobe = rt; wrEn = we; wrData = wd;
    cm = mWord[4:0]; entry = 1; setF = 0; tgt = 5'b10011; vec = 3'd0;
    if (rs)                    begin tgt = 5'b10011; setF = 1; vec = 3'd0; end
    else if (ab)               begin tgt = 5'b10111; vec = 3'd3; end
    else if (fq && !mWord[6])  begin tgt = 5'b10001; setF = 1; vec = 3'd5; end
    else if (iq && !mWord[7])  begin tgt = 5'b10010; vec = 3'd4; end
    else if (ud)               begin tgt = 5'b11011; vec = 3'd1; end
    else if (sw)               begin tgt = 5'b10011; vec = 3'd2; end
    else entry = 0;
    if (entry) begin
      mSaved[slotOf(tgt)] = mWord;
      mWord = {mWord[31:28], 20'b0, 1'b1, mWord[6] | setF, 1'b0, tgt};
      mTaken = 1; mVec = vec;
    end else begin
      mTaken = 0;
      if (rt && slotOf(cm) >= 0) mWord = mSaved[slotOf(cm)];
      else if (we) begin
        if (cm == 5'b10000) mWord = {wd[31:28], mWord[27:0]};
        else mWord = {wd[31:28], 20'b0, wd[7:5], legalMode(wd[4:0]) ? wd[4:0] : cm};
      end
    end
    expQ.push_back(snapshot(tag));
  endtask

  task automatic idle(input string tag);
    drive(0,0,0,0,0,0,0,0, 32'h0, tag);
  endtask

  // Monitor: pop and compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) compareNow(expQ.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    mWord = {4'b0, 20'b0, 1'b1, 1'b1, 1'b0, 5'b10011};
    for (int k = 0; k < 5; k++) mSaved[k] = '0;
    mVec = 0; mTaken = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1 compareNow(snapshot("R1 reset state"));
    idle("R1 idle after reset");
    drive(0,0,0,0,0,0,0,1, 32'hA000_0013, "R9 privileged write");
    drive(0,0,0,0,0,0,0,1, 32'h5000_0015, "R9 illegal mode kept");
    drive(0,0,0,1,0,0,0,0, 32'h0, "R6 normal interrupt entry");
    idle("R11 strobe drops, index holds");
    drive(0,0,0,1,0,0,0,0, 32'h0, "R3 masked normal interrupt");
    drive(0,0,1,0,0,0,0,0, 32'h0, "R5 fast entry sets F");
    drive(0,0,0,0,0,0,1,0, 32'h0, "R7 return from fast");
    drive(0,0,0,0,0,0,1,0, 32'h0, "R7 return from normal");
    drive(0,0,0,0,0,0,0,1, 32'h3000_0010, "R9 write to user");
    drive(0,0,0,0,0,0,0,1, 32'hF000_00F3, "R8 user write only flags");
    drive(0,0,0,0,0,0,1,0, 32'h0, "R7 return ignored in user");
    drive(0,1,1,1,1,1,0,0, 32'h0, "R2 abort wins R4");
    drive(0,0,0,0,0,0,0,1, 32'h0000_0010, "R9 abort to user");
    drive(0,0,1,1,1,1,0,0, 32'h0, "R2 fast wins");
    drive(0,0,0,1,1,1,0,0, 32'h0, "R3 masked normal, undefined wins R2");
    drive(0,0,0,0,0,1,1,1, 32'h0000_0010, "R10 entry beats return and write");
    drive(0,0,0,0,0,0,1,1, 32'h0000_0010, "R10 return beats write");
    drive(0,0,0,0,0,0,0,1, 32'h0000_001F, "R9 write to system");
    drive(0,0,0,0,0,0,1,0, 32'h0, "R7 return ignored in system");
    drive(1,1,1,1,1,1,1,1, 32'h0000_0010, "R2 reset wins R5");
    drive(0,0,1,0,0,0,0,0, 32'h0, "R3 masked fast");
    drive(0,0,0,0,0,1,0,0, 32'h0, "R6 software interrupt entry");
    idle("R11 final idle");
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule